// File: doc/BRIEF.md
# Per-Interrupt Pending and Active State Tracker

This block keeps the run-time state of every interrupt in a small multi-core interrupt distributor. For each interrupt it stores five per-CPU bit masks: enable, latched pending, active, registered line level and group. It also stores two per-interrupt flags: a trigger-kind flag (edge or level) and a model flag that makes an acknowledge clear the pending state for all CPUs. Software-style set and clear commands carry a CPU mask. Acknowledge and deactivate requests carry a single CPU index. Interrupt line levels come in as one bit per interrupt per CPU.

A query port selects one interrupt. The block returns that interrupt's per-CPU enable, effective pending, active and group bits as combinational outputs. In normal mode a level-triggered interrupt counts as pending while its registered line is high, even when no pending bit is latched. A legacy mode reports only the latched bit. Interrupts below the private boundary (32) are deactivated per CPU. Interrupts at or above it are shared, and a deactivate clears them for every CPU.

Top module: `irq_state_tracker`

## Requirements
- R1: After synchronous reset every mask and both flags are zero, so a query of any interrupt returns all-zero enable, pending, active and group bits.
- R2: A command (`cmd_op` 1/2 enable set/clear, 3/4 pending set/clear, 5/6 active set/clear, 7/8 group set/clear) changes only the CPU bits given in `cmd_mask` and is visible one clock later. Codes 9/10 mark the interrupt edge/level-triggered, codes 11/12 set/clear its model flag, and these four ignore the mask. Code 0 does nothing.
- R3: In normal mode (`legacy_mode`=0) the effective pending bit is the latched bit OR, for a level-triggered interrupt, the line level. Line levels pass one register, so a level driven before clock edge k is seen after edge k.
- R4: With `legacy_mode`=1 the line level is ignored and only latched pending bits are reported.
- R5: For an edge-triggered interrupt, a 0-to-1 change of the registered line for a CPU latches that CPU's pending bit one clock after the line is seen. A line held high or dropped does not change the latched bit, and the line alone never shows as pending.
- R6: An acknowledge with the model flag clear clears the pending bit only for `ack_cpu` and sets the active bit only for `ack_cpu`.
- R7: An acknowledge of an interrupt whose model flag is set clears the pending bit for all CPUs and sets the active bit only for `ack_cpu`.
- R8: A level-triggered interrupt whose line is still high remains pending after its acknowledge, and stops being pending once the line drops.
- R9: A deactivate of an interrupt numbered below 32 clears the active bit only for `deact_cpu`. For an interrupt numbered 32 or above it clears the active bit for all CPUs.
- R10: A pending-set command and a latching rising edge on the same interrupt in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | 1: report only latched pending bits |
| line_lvl | input | NIRQ*NCPU | Line levels, bit irq*NCPU+cpu |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command code (see R2) |
| cmd_irq | input | log2(NIRQ) | Command target interrupt |
| cmd_mask | input | NCPU | CPU mask for mask commands |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_irq | input | log2(NIRQ) | Acknowledged interrupt |
| ack_cpu | input | log2(NCPU) | Acknowledging CPU |
| deact_valid | input | 1 | Deactivate strobe |
| deact_irq | input | log2(NIRQ) | Deactivated interrupt |
| deact_cpu | input | log2(NCPU) | Requesting CPU |
| query_irq | input | log2(NIRQ) | Interrupt selected for the outputs |
| q_enable | output | NCPU | Enable mask of the queried interrupt |
| q_pending | output | NCPU | Effective pending bits of the queried interrupt |
| q_active | output | NCPU | Active mask of the queried interrupt |
| q_group | output | NCPU | Group mask of the queried interrupt |

## Verification
A wrong bit in any stored mask shows up on the query outputs in the same cycle that the interrupt is selected. A wrong update therefore appears one clock after the command, acknowledge or deactivate that caused it. A trigger-flag or line-register fault shows up as a pending bit that appears one clock early, one clock late or not at all. A model-flag fault or a wrong private/shared split shows up as a wrong set of CPU bits surviving an acknowledge or deactivate. The directed scenarios place reads at exactly these cycles, including interrupts 31 and 32 on either side of the boundary.

// File: rtl/irqst_pkg.sv
`timescale 1ns/1ps
package irqst_pkg;

    // Command codes carried on cmd_op
    typedef enum logic [3:0] {
        OP_NOP        = 4'd0,
        OP_EN_SET     = 4'd1,
        OP_EN_CLR     = 4'd2,
        OP_PEND_SET   = 4'd3,
        OP_PEND_CLR   = 4'd4,
        OP_ACT_SET    = 4'd5,
        OP_ACT_CLR    = 4'd6,
        OP_GRP_SET    = 4'd7,
        OP_GRP_CLR    = 4'd8,
        OP_TRIG_EDGE  = 4'd9,
        OP_TRIG_LEVEL = 4'd10,
        OP_MODEL_SET  = 4'd11,
        OP_MODEL_CLR  = 4'd12
    } cmd_op_e;

    // Per-interrupt flags
    typedef struct packed {
        logic trig_edge;
        logic model;
    } irq_flags_t;

    // Boundary between per-CPU private and shared interrupts
    localparam int unsigned PRIVATE_LIMIT = 32;

endpackage

// File: rtl/irqst_line_stage.sv
`timescale 1ns/1ps
module irqst_line_stage #(
    parameter int unsigned W = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] line_in,
    output logic [W-1:0] lvl_q,
    output logic [W-1:0] rise
);
    logic [W-1:0] lvl_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q    <= '0;
            lvl_prev <= '0;
        end else begin
            lvl_q    <= line_in;
            lvl_prev <= lvl_q;
        end
    end

    // Rising edge of the registered level
    assign rise = lvl_q & ~lvl_prev;
endmodule

// File: rtl/irqst_slot.sv
`timescale 1ns/1ps
module irqst_slot
    import irqst_pkg::*;
#(
    parameter int unsigned NCPU      = 4,
    parameter int unsigned IRQ_ID    = 0,
    parameter int unsigned NINTERNAL = PRIVATE_LIMIT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_hit,
    input  logic [3:0]      cmd_op,
    input  logic [NCPU-1:0] cmd_mask,
    input  logic            ack_hit,
    input  logic [NCPU-1:0] ack_sel,
    input  logic            deact_hit,
    input  logic [NCPU-1:0] deact_sel,
    input  logic [NCPU-1:0] rise,
    output logic [NCPU-1:0] en_o,
    output logic [NCPU-1:0] pend_o,
    output logic [NCPU-1:0] act_o,
    output logic [NCPU-1:0] grp_o,
    output irq_flags_t      flags_o
);
    localparam bit              IS_PRIVATE = (IRQ_ID < NINTERNAL);
    localparam logic [NCPU-1:0] ALL_CPUS   = {NCPU{1'b1}};

    logic [NCPU-1:0] en_q, pend_q, act_q, grp_q;
    logic [NCPU-1:0] en_n, pend_n, act_n, grp_n;
    irq_flags_t      flg_q, flg_n;
    cmd_op_e         op;

    assign op = cmd_op_e'(cmd_op);

    always_comb begin
        en_n   = en_q;
        pend_n = pend_q;
        act_n  = act_q;
        grp_n  = grp_q;
        flg_n  = flg_q;
        // 1) register-style commands
        if (cmd_hit) begin
            unique case (op)
                OP_EN_SET:     en_n   = en_q   |  cmd_mask;
                OP_EN_CLR:     en_n   = en_q   & ~cmd_mask;
                OP_PEND_SET:   pend_n = pend_q |  cmd_mask;
                OP_PEND_CLR:   pend_n = pend_q & ~cmd_mask;
                OP_ACT_SET:    act_n  = act_q  |  cmd_mask;
                OP_ACT_CLR:    act_n  = act_q  & ~cmd_mask;
                OP_GRP_SET:    grp_n  = grp_q  |  cmd_mask;
                OP_GRP_CLR:    grp_n  = grp_q  & ~cmd_mask;
                OP_TRIG_EDGE:  flg_n.trig_edge = 1'b1;
                OP_TRIG_LEVEL: flg_n.trig_edge = 1'b0;
                OP_MODEL_SET:  flg_n.model     = 1'b1;
                OP_MODEL_CLR:  flg_n.model     = 1'b0;
                default: ;
            endcase
        end
        // 2) acknowledge: pending scope depends on the model flag
        if (ack_hit) begin
            pend_n = pend_n & ~(flg_q.model ? ALL_CPUS : ack_sel);
            act_n  = act_n | ack_sel;
        end
        // 3) deactivate: private interrupts per CPU, shared ones for all
        if (deact_hit) begin
            act_n = act_n & ~(IS_PRIVATE ? deact_sel : ALL_CPUS);
        end
        // 4) edge latch
        if (flg_q.trig_edge) begin
            pend_n = pend_n | rise;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
            grp_q  <= '0;
            flg_q  <= '0;
        end else begin
            en_q   <= en_n;
            pend_q <= pend_n;
            act_q  <= act_n;
            grp_q  <= grp_n;
            flg_q  <= flg_n;
        end
    end

    assign en_o    = en_q;
    assign pend_o  = pend_q;
    assign act_o   = act_q;
    assign grp_o   = grp_q;
    assign flags_o = flg_q;
endmodule

// File: rtl/irq_state_tracker.sv
`timescale 1ns/1ps
module irq_state_tracker
    import irqst_pkg::*;
#(
    parameter int unsigned NCPU      = 4,
    parameter int unsigned NIRQ      = 64,
    parameter int unsigned NINTERNAL = PRIVATE_LIMIT,
    localparam int unsigned IRQ_W    = $clog2(NIRQ),
    localparam int unsigned CPU_W    = $clog2(NCPU)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 legacy_mode,
    input  logic [NIRQ*NCPU-1:0] line_lvl,
    input  logic                 cmd_valid,
    input  logic [3:0]           cmd_op,
    input  logic [IRQ_W-1:0]     cmd_irq,
    input  logic [NCPU-1:0]      cmd_mask,
    input  logic                 ack_valid,
    input  logic [IRQ_W-1:0]     ack_irq,
    input  logic [CPU_W-1:0]     ack_cpu,
    input  logic                 deact_valid,
    input  logic [IRQ_W-1:0]     deact_irq,
    input  logic [CPU_W-1:0]     deact_cpu,
    input  logic [IRQ_W-1:0]     query_irq,
    output logic [NCPU-1:0]      q_enable,
    output logic [NCPU-1:0]      q_pending,
    output logic [NCPU-1:0]      q_active,
    output logic [NCPU-1:0]      q_group
);
    localparam logic [NCPU-1:0] ONE_HOT0 = {{(NCPU-1){1'b0}}, 1'b1};

    logic [NIRQ*NCPU-1:0]       lvl_flat, rise_flat;
    logic [NIRQ-1:0][NCPU-1:0]  lvl_a, rise_a;
    logic [NIRQ-1:0][NCPU-1:0]  en_a, pend_a, act_a, grp_a;
    logic [NIRQ-1:0]            edge_a, model_a;
    logic [NCPU-1:0]            ack_sel, deact_sel;

    irqst_line_stage #(.W(NIRQ*NCPU)) u_lines (
        .clk     (clk),
        .rst     (rst),
        .line_in (line_lvl),
        .lvl_q   (lvl_flat),
        .rise    (rise_flat)
    );

    assign lvl_a     = lvl_flat;
    assign rise_a    = rise_flat;
    assign ack_sel   = ONE_HOT0 << ack_cpu;
    assign deact_sel = ONE_HOT0 << deact_cpu;

    for (genvar g = 0; g < NIRQ; g++) begin : g_slot
        irq_flags_t flg;

        irqst_slot #(
            .NCPU      (NCPU),
            .IRQ_ID    (g),
            .NINTERNAL (NINTERNAL)
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .cmd_hit   (cmd_valid && (cmd_irq == IRQ_W'(g))),
            .cmd_op    (cmd_op),
            .cmd_mask  (cmd_mask),
            .ack_hit   (ack_valid && (ack_irq == IRQ_W'(g))),
            .ack_sel   (ack_sel),
            .deact_hit (deact_valid && (deact_irq == IRQ_W'(g))),
            .deact_sel (deact_sel),
            .rise      (rise_a[g]),
            .en_o      (en_a[g]),
            .pend_o    (pend_a[g]),
            .act_o     (act_a[g]),
            .grp_o     (grp_a[g]),
            .flags_o   (flg)
        );

        assign edge_a[g]  = flg.trig_edge;
        assign model_a[g] = flg.model;
    end

    // Query view: level lines count only for level-triggered interrupts
    always_comb begin
        q_enable  = en_a[query_irq];
        q_active  = act_a[query_irq];
        q_group   = grp_a[query_irq];
        q_pending = pend_a[query_irq];
        if (!legacy_mode && !edge_a[query_irq]) begin
            q_pending = q_pending | lvl_a[query_irq];
        end
    end
endmodule

// File: rtl/irqst_checker.sv
`timescale 1ns/1ps
module irqst_checker
    import irqst_pkg::*;
#(
    parameter int unsigned NCPU      = 4,
    parameter int unsigned NIRQ      = 64,
    parameter int unsigned NINTERNAL = PRIVATE_LIMIT,
    localparam int unsigned IRQ_W    = $clog2(NIRQ),
    localparam int unsigned CPU_W    = $clog2(NCPU)
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      legacy_mode,
    input logic                      cmd_valid,
    input logic [3:0]                cmd_op,
    input logic [IRQ_W-1:0]          cmd_irq,
    input logic [NCPU-1:0]           cmd_mask,
    input logic                      ack_valid,
    input logic [IRQ_W-1:0]          ack_irq,
    input logic [CPU_W-1:0]          ack_cpu,
    input logic                      deact_valid,
    input logic [IRQ_W-1:0]          deact_irq,
    input logic [CPU_W-1:0]          deact_cpu,
    input logic [IRQ_W-1:0]          query_irq,
    input logic [NCPU-1:0]           q_pending,
    input logic [NIRQ-1:0][NCPU-1:0] pend_a,
    input logic [NIRQ-1:0][NCPU-1:0] act_a,
    input logic [NIRQ-1:0][NCPU-1:0] lvl_a,
    input logic [NIRQ-1:0]           edge_a,
    input logic [NIRQ-1:0]           model_a
);
    logic [NCPU-1:0] dsel;
    logic            ack_cmd_clash, deact_other, deact_private;

    assign dsel          = {{(NCPU-1){1'b0}}, 1'b1} << deact_cpu;
    assign ack_cmd_clash = cmd_valid && (cmd_irq == ack_irq);
    assign deact_other   = (ack_valid && ack_irq == deact_irq) ||
                           (cmd_valid && cmd_irq == deact_irq);
    assign deact_private = ({1'b0, deact_irq} < (IRQ_W+1)'(NINTERNAL));

    // R6: acknowledging CPU becomes active
    p_ack_active_r6: assert property (@(posedge clk) disable iff (rst)
        ack_valid && !(deact_valid && deact_irq == ack_irq)
        |=> act_a[$past(ack_irq)][$past(ack_cpu)]);

    // R7: model-flag acknowledge clears pending for every CPU
    p_model_ack_r7: assert property (@(posedge clk) disable iff (rst)
        ack_valid && model_a[ack_irq] && !edge_a[ack_irq] && !ack_cmd_clash
        |=> pend_a[$past(ack_irq)] == '0);

    // R9: private deactivate touches only the requesting CPU
    p_deact_private_r9: assert property (@(posedge clk) disable iff (rst)
        deact_valid && deact_private && !deact_other
        |=> act_a[$past(deact_irq)] == ($past(act_a[deact_irq]) & ~$past(dsel)));

    // R9: shared deactivate clears every CPU
    p_deact_shared_r9: assert property (@(posedge clk) disable iff (rst)
        deact_valid && !deact_private && !deact_other
        |=> act_a[$past(deact_irq)] == '0);

    // R2: pending-set command leaves the masked bits set
    p_pend_set_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_op == OP_PEND_SET && !(ack_valid && ack_irq == cmd_irq)
        |=> (pend_a[$past(cmd_irq)] & $past(cmd_mask)) == $past(cmd_mask));

    // R3: a high line on a level-triggered interrupt reads as pending
    p_level_pending_r3: assert property (@(posedge clk) disable iff (rst)
        !legacy_mode && !edge_a[query_irq]
        |-> (q_pending & lvl_a[query_irq]) == lvl_a[query_irq]);
endmodule

bind irq_state_tracker irqst_checker #(
    .NCPU      (NCPU),
    .NIRQ      (NIRQ),
    .NINTERNAL (NINTERNAL)
) u_checker (
    .clk         (clk),
    .rst         (rst),
    .legacy_mode (legacy_mode),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_irq     (cmd_irq),
    .cmd_mask    (cmd_mask),
    .ack_valid   (ack_valid),
    .ack_irq     (ack_irq),
    .ack_cpu     (ack_cpu),
    .deact_valid (deact_valid),
    .deact_irq   (deact_irq),
    .deact_cpu   (deact_cpu),
    .query_irq   (query_irq),
    .q_pending   (q_pending),
    .pend_a      (pend_a),
    .act_a       (act_a),
    .lvl_a       (lvl_a),
    .edge_a      (edge_a),
    .model_a     (model_a)
);

// File: tb/irq_state_tracker_bench.sv
`timescale 1ns/1ps
module irq_state_tracker_bench;
    import irqst_pkg::*;

    localparam int NCPU = 4;
    localparam int NIRQ = 64;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 legacy_mode = 1'b0;
    logic [NIRQ*NCPU-1:0] line_lvl = '0;
    logic                 cmd_valid = 1'b0;
    logic [3:0]           cmd_op = '0;
    logic [5:0]           cmd_irq = '0;
    logic [3:0]           cmd_mask = '0;
    logic                 ack_valid = 1'b0;
    logic [5:0]           ack_irq = '0;
    logic [1:0]           ack_cpu = '0;
    logic                 deact_valid = 1'b0;
    logic [5:0]           deact_irq = '0;
    logic [1:0]           deact_cpu = '0;
    logic [5:0]           query_irq = '0;
    logic [3:0]           q_enable, q_pending, q_active, q_group;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    irq_state_tracker u_irq_state_tracker (
        .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .line_lvl(line_lvl),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_irq(cmd_irq), .cmd_mask(cmd_mask),
        .ack_valid(ack_valid), .ack_irq(ack_irq), .ack_cpu(ack_cpu),
        .deact_valid(deact_valid), .deact_irq(deact_irq), .deact_cpu(deact_cpu),
        .query_irq(query_irq), .q_enable(q_enable), .q_pending(q_pending),
        .q_active(q_active), .q_group(q_group)
    );

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic look(input int irq);
        query_irq = 6'(irq);
        #1;
    endtask

    // All drivers change at a falling edge and hold for one rising edge
    task automatic cmd(input cmd_op_e op, input int irq, input logic [3:0] m);
        cmd_valid = 1'b1; cmd_op = op; cmd_irq = 6'(irq); cmd_mask = m;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ack(input int irq, input int cpu);
        ack_valid = 1'b1; ack_irq = 6'(irq); ack_cpu = 2'(cpu);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic deact(input int irq, input int cpu);
        deact_valid = 1'b1; deact_irq = 6'(irq); deact_cpu = 2'(cpu);
        @(negedge clk);
        deact_valid = 1'b0;
    endtask

    task automatic set_line(input int irq, input int cpu, input logic v);
        line_lvl[irq*NCPU + cpu] = v;
    endtask

    task automatic t_reset;
        foreach (u_irq_state_tracker.q_enable[i]) ; // no-op to keep the loop form local
        for (int irq = 0; irq < NIRQ; irq += 21) begin
            look(irq);
            check("R1 enable", q_enable, 4'b0000);
            check("R1 pending", q_pending, 4'b0000);
            check("R1 active|group", q_active | q_group, 4'b0000);
        end
    endtask

    task automatic t_commands;
        cmd(OP_EN_SET, 5, 4'b0101);   look(5);  check("R2 enable set", q_enable, 4'b0101);
        cmd(OP_EN_CLR, 5, 4'b0001);   look(5);  check("R2 enable clear", q_enable, 4'b0100);
        cmd(OP_GRP_SET, 40, 4'b1000); look(40); check("R2 group set", q_group, 4'b1000);
        look(5);  check("R2 other irq group", q_group, 4'b0000);
        cmd(OP_PEND_SET, 40, 4'b0011); look(40); check("R2 pending set", q_pending, 4'b0011);
        cmd(OP_PEND_CLR, 40, 4'b0001); look(40); check("R2 pending clear", q_pending, 4'b0010);
        cmd(OP_NOP, 40, 4'b1111);      look(40); check("R2 nop pending", q_pending, 4'b0010);
        check("R2 nop enable", q_enable, 4'b0000);
    endtask

    task automatic t_level;
        set_line(10, 2, 1'b1);
        look(10); check("R3 level not yet registered", q_pending, 4'b0000);
        @(negedge clk); look(10); check("R3 level pending", q_pending, 4'b0100);
        legacy_mode = 1'b1; look(10); check("R4 legacy ignores line", q_pending, 4'b0000);
        legacy_mode = 1'b0;
        set_line(10, 2, 1'b0);
        @(negedge clk); look(10); check("R3 level dropped", q_pending, 4'b0000);
    endtask

    task automatic t_edge;
        cmd(OP_TRIG_EDGE, 50, 4'b0000);
        set_line(50, 1, 1'b1);
        @(negedge clk); look(50); check("R5 line alone not pending", q_pending, 4'b0000);
        @(negedge clk); look(50); check("R5 edge latched", q_pending, 4'b0010);
        set_line(50, 1, 1'b0);
        repeat (2) @(negedge clk);
        look(50); check("R5 latched after drop", q_pending, 4'b0010);
        legacy_mode = 1'b1; look(50); check("R4 legacy latched", q_pending, 4'b0010);
        legacy_mode = 1'b0;
    endtask

    task automatic t_ack;
        ack(50, 1); look(50);
        check("R6 pending cleared", q_pending, 4'b0000);
        check("R6 active set", q_active, 4'b0010);
        cmd(OP_PEND_SET, 50, 4'b1111);
        ack(50, 0); look(50);
        check("R6 only cpu0 pending cleared", q_pending, 4'b1110);
        check("R6 cpu0 active added", q_active, 4'b0011);
    endtask

    task automatic t_model;
        cmd(OP_MODEL_SET, 60, 4'b0000);
        cmd(OP_PEND_SET, 60, 4'b1111);
        ack(60, 3); look(60);
        check("R7 model ack clears all", q_pending, 4'b0000);
        check("R7 model ack active", q_active, 4'b1000);
    endtask

    task automatic t_level_ack;
        set_line(12, 0, 1'b1);
        cmd(OP_PEND_SET, 12, 4'b0001);
        ack(12, 0); look(12);
        check("R8 level still pending", q_pending, 4'b0001);
        check("R8 active", q_active, 4'b0001);
        set_line(12, 0, 1'b0);
        @(negedge clk); look(12);
        check("R8 pending gone after drop", q_pending, 4'b0000);
    endtask

    task automatic t_deact;
        cmd(OP_ACT_SET, 12, 4'b1111);
        deact(12, 0); look(12); check("R9 private deact", q_active, 4'b1110);
        deact(50, 1); look(50); check("R9 shared deact", q_active, 4'b0000);
        cmd(OP_ACT_SET, 31, 4'b1111);
        cmd(OP_ACT_SET, 32, 4'b1111);
        deact(31, 2); look(31); check("R9 irq31 private", q_active, 4'b1011);
        deact(32, 2); look(32); check("R9 irq32 shared", q_active, 4'b0000);
        cmd(OP_ACT_CLR, 31, 4'b0011); look(31); check("R2 active clear", q_active, 4'b1000);
    endtask

    task automatic t_collide;
        cmd(OP_TRIG_EDGE, 20, 4'b0000);
        set_line(20, 3, 1'b1);
        @(negedge clk);
        // rise for cpu3 is live during the next rising edge, as is the command
        cmd(OP_PEND_SET, 20, 4'b0001);
        look(20); check("R10 edge and set together", q_pending, 4'b1001);
        cmd(OP_TRIG_LEVEL, 20, 4'b0000);
        cmd(OP_PEND_CLR, 20, 4'b1111);
        look(20); check("R2 level flag shows line", q_pending, 4'b1000);
        set_line(20, 3, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_commands();
        t_level();
        t_edge();
        t_ack();
        t_model();
        t_level_ack();
        t_deact();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule